// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block is a bus-master copy engine. It walks a circular table of 16-byte descriptors in system memory. Each descriptor names a target offset, a system source address and a command word. For every descriptor the engine reads a run of dwords from the source address and sends each dword, tagged with a target offset, out on a ready/valid stream toward a register file or data port. The target offset either steps by four per dword or stays fixed on one port.

Software loads the starting table address and a ring-size code with a single command write while the engine is idle, then pulses a start input. The engine fetches and executes descriptors one after another until it completes one whose command word carries the end-of-list flag. The command word is fetched fresh from memory each time a descriptor is reached, so software can extend a running list by clearing that flag in the old last descriptor. The table pointer output is one descriptor ahead of the one executing while the engine is busy. When the engine stops, that pointer names the next descriptor to run, so a later start resumes where the list ended.

Top module: `descRingDma`

## Requirements
- R1: After reset `busy`, `memReq`, `outValid` and `eolIrq` are low and `tablePtr` is zero.
- R2: A `cmdWrEn` cycle while idle loads `tablePtr` with `cmdWrData` with bits [3:0] forced to zero and takes the ring-size code from `cmdWrData[1:0]`. The ring is 16 KB shifted left by the code (0=16K, 1=32K, 2=64K, 3=128K). A command write while busy is ignored.
- R3: A `kick` pulse while idle raises `busy`. The descriptor at `tablePtr` is then read as dword reads at offsets +0 (target offset), +4 (source address) and +8 (command word), in that order. The word at +12 is never read. A kick while busy is ignored.
- R4: `tablePtr` advances by 16 as soon as a descriptor's command word is returned, so during streaming it equals that descriptor's address plus 16. It wraps to the start of its ring, whose base is `tablePtr` with the low log2(ring size) bits cleared, and its low 4 bits are always zero.
- R5: The byte count is command bits [12:0]. A value above 4096 is treated as 4096, and the number of dwords sent is the byte count divided by four, rounded up.
- R6: Each dword costs exactly one memory read at source address, +4, +8 and so on. At most one read is outstanding, and the engine waits for `memRdValid` before it goes on.
- R7: Each output dword equals the data read for it. `outAddr` is the target offset plus 4 per dword already sent, or stays at the target offset when command bit 30 (hold) is set.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outAddr` hold their values.
- R9: A descriptor whose byte count is zero issues no data read and no output.
- R10: Command bit 31 (end of list) stops the engine after that descriptor's last dword is accepted, or right after its command read if the count is zero. `eolIrq` is high for exactly one cycle: the first cycle in which `busy` is low.
- R11: A descriptor without end of list is followed directly by the next descriptor in the ring. Its command word is read from memory at that time, so a flag cleared by software during the run takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Table command write strobe |
| cmdWrData | input | 32 | Table start address (bits 31:4) and ring-size code (bits 1:0) |
| kick | input | 1 | Start walking descriptors from the table pointer |
| memReq | output | 1 | One-cycle dword read request |
| memReqAddr | output | 32 | Byte address of the requested dword |
| memRdValid | input | 1 | Read data returned this cycle |
| memRdData | input | 32 | Returned dword |
| outValid | output | 1 | Output dword valid |
| outReady | input | 1 | Output sink accepts the dword |
| outAddr | output | 32 | Target offset of the output dword |
| outData | output | 32 | Output dword |
| tablePtr | output | 32 | Current descriptor table pointer |
| busy | output | 1 | Engine is walking the list |
| eolIrq | output | 1 | One-cycle end-of-list pulse |

## Verification
Every cycle the assertions check the output hold under backpressure, the single-cycle end-of-list pulse and its link to `busy` falling, and the single outstanding read. They also check that nothing is requested or offered while idle, that the pointer stays 16-byte aligned and that a command write while idle lands in the pointer. Only the bench scenarios can show the read order inside a descriptor, the byte-count rounding and the 4096-byte clamp, and the data and target sequences with and without hold. The same goes for ring wrap under different size codes, zero-count skipping and a list extended by software mid-run.

// File: rtl/descRingDmaPkg.sv
package descRingDmaPkg;

  localparam int DESC_BYTES = 16;
  localparam int EOL_BIT    = 31;
  localparam int HOLD_BIT   = 30;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ_TGT,
    ST_WAIT_TGT,
    ST_REQ_SRC,
    ST_WAIT_SRC,
    ST_REQ_CMD,
    ST_WAIT_CMD,
    ST_DECIDE,
    ST_REQ_DATA,
    ST_WAIT_DATA,
    ST_SEND
  } dmaState_e;

  typedef enum logic [1:0] {
    ASEL_TGT,
    ASEL_SRC,
    ASEL_CMD,
    ASEL_DATA
  } addrSel_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     loadPtr;
    logic     ldTgt;
    logic     ldSrc;
    logic     ldCmd;
    logic     ldData;
    logic     stepOut;
    addrSel_e addrSel;
  } dpCtrl_t;

endpackage

// File: rtl/descRingDmaDatapath.sv
module descRingDmaDatapath
  import descRingDmaPkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int MAX_BYTES      = 4096,
  parameter int CNT_FIELD_W    = 13,
  parameter int RING_MIN_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] memReqAddr,
  output logic [WORD_W-1:0] outAddr,
  output logic [WORD_W-1:0] outData,
  output logic [WORD_W-1:0] tablePtr,
  output logic              cntZero,
  output logic              cntOne,
  output logic              eolFlag
);

  localparam int STEP  = WORD_W / 8;
  localparam int CNT_W = $clog2(MAX_BYTES / STEP + 1);

  logic [WORD_W-1:0]      ptrQ, tgtQ, srcQ, dataQ;
  logic [1:0]             sizeQ;
  logic [CNT_W-1:0]       cntQ;
  logic                   holdQ, eolQ;

  logic [WORD_W-1:0]      ringMask, ptrNext;
  logic [CNT_FIELD_W-1:0] byteField, byteClamp;
  logic [CNT_FIELD_W:0]   roundUp;
  logic [CNT_W-1:0]       dwordCnt;
  logic                   unusedCmdBits;

  assign unusedCmdBits = ^cmdWrData[3:2];

  // Ring wrap: keep the bits above the ring size, step within it
  always_comb begin
    ringMask  = (WORD_W'(RING_MIN_BYTES) << sizeQ) - WORD_W'(1);
    ptrNext   = (ptrQ & ~ringMask) | ((ptrQ + WORD_W'(DESC_BYTES)) & ringMask);
    byteField = memRdData[CNT_FIELD_W-1:0];
    byteClamp = (byteField > CNT_FIELD_W'(MAX_BYTES)) ? CNT_FIELD_W'(MAX_BYTES) : byteField;
    roundUp   = {1'b0, byteClamp} + (CNT_FIELD_W + 1)'(STEP - 1);
    dwordCnt  = CNT_W'(roundUp >> $clog2(STEP));
  end

  always_comb begin
    unique case (dp.addrSel)
      ASEL_TGT: memReqAddr = ptrQ;
      ASEL_SRC: memReqAddr = ptrQ + WORD_W'(STEP);
      ASEL_CMD: memReqAddr = ptrQ + WORD_W'(2 * STEP);
      default:  memReqAddr = srcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      sizeQ <= '0;
      tgtQ  <= '0;
      srcQ  <= '0;
      dataQ <= '0;
      cntQ  <= '0;
      holdQ <= 1'b0;
      eolQ  <= 1'b0;
    end else begin
      if (dp.loadPtr) begin
        ptrQ  <= {cmdWrData[WORD_W-1:4], 4'b0000};
        sizeQ <= cmdWrData[1:0];
      end else if (dp.ldCmd) begin
        ptrQ  <= ptrNext;
      end
      if (dp.ldTgt) tgtQ <= memRdData;
      if (dp.ldSrc) srcQ <= memRdData;
      if (dp.ldCmd) begin
        cntQ  <= dwordCnt;
        holdQ <= memRdData[HOLD_BIT];
        eolQ  <= memRdData[EOL_BIT];
      end
      if (dp.ldData) dataQ <= memRdData;
      if (dp.stepOut) begin
        srcQ <= srcQ + WORD_W'(STEP);
        tgtQ <= holdQ ? tgtQ : tgtQ + WORD_W'(STEP);
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  assign outAddr  = tgtQ;
  assign outData  = dataQ;
  assign tablePtr = ptrQ;
  assign cntZero  = (cntQ == '0);
  assign cntOne   = (cntQ == CNT_W'(1));
  assign eolFlag  = eolQ;

endmodule

// File: rtl/descRingDmaCtrl.sv
module descRingDmaCtrl
  import descRingDmaPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdWrEn,
  input  logic    kick,
  input  logic    memRdValid,
  input  logic    outReady,
  input  logic    cntZero,
  input  logic    cntOne,
  input  logic    eolFlag,
  output dpCtrl_t dp,
  output logic    memReq,
  output logic    outValid,
  output logic    busy,
  output logic    eolIrq
);

  dmaState_e stateQ, stateD;
  logic      irqD, descDone;

  always_comb begin
    stateD     = stateQ;
    irqD       = 1'b0;
    descDone   = 1'b0;
    dp         = '0;
    dp.addrSel = ASEL_DATA;
    unique case (stateQ)
      ST_IDLE: begin
        dp.loadPtr = cmdWrEn;
        if (kick) stateD = ST_REQ_TGT;
      end
      ST_REQ_TGT: begin
        dp.addrSel = ASEL_TGT;
        stateD     = ST_WAIT_TGT;
      end
      ST_WAIT_TGT: if (memRdValid) begin
        dp.ldTgt = 1'b1;
        stateD   = ST_REQ_SRC;
      end
      ST_REQ_SRC: begin
        dp.addrSel = ASEL_SRC;
        stateD     = ST_WAIT_SRC;
      end
      ST_WAIT_SRC: if (memRdValid) begin
        dp.ldSrc = 1'b1;
        stateD   = ST_REQ_CMD;
      end
      ST_REQ_CMD: begin
        dp.addrSel = ASEL_CMD;
        stateD     = ST_WAIT_CMD;
      end
      ST_WAIT_CMD: if (memRdValid) begin
        dp.ldCmd = 1'b1;
        stateD   = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (cntZero) descDone = 1'b1;
        else         stateD   = ST_REQ_DATA;
      end
      ST_REQ_DATA: stateD = ST_WAIT_DATA;
      ST_WAIT_DATA: if (memRdValid) begin
        dp.ldData = 1'b1;
        stateD    = ST_SEND;
      end
      ST_SEND: if (outReady) begin
        dp.stepOut = 1'b1;
        if (cntOne) descDone = 1'b1;
        else        stateD   = ST_REQ_DATA;
      end
      default: stateD = ST_IDLE;
    endcase
    if (descDone) begin
      if (eolFlag) begin
        stateD = ST_IDLE;
        irqD   = 1'b1;
      end else begin
        stateD = ST_REQ_TGT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      eolIrq <= 1'b0;
    end else begin
      stateQ <= stateD;
      eolIrq <= irqD;
    end
  end

  assign memReq   = (stateQ == ST_REQ_TGT) || (stateQ == ST_REQ_SRC) ||
                    (stateQ == ST_REQ_CMD) || (stateQ == ST_REQ_DATA);
  assign outValid = (stateQ == ST_SEND);
  assign busy     = (stateQ != ST_IDLE);

endmodule

// File: rtl/descRingDma.sv
module descRingDma
  import descRingDmaPkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int MAX_BYTES      = 4096,
  parameter int CNT_FIELD_W    = 13,
  parameter int RING_MIN_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              kick,
  output logic              memReq,
  output logic [WORD_W-1:0] memReqAddr,
  input  logic              memRdValid,
  input  logic [WORD_W-1:0] memRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outAddr,
  output logic [WORD_W-1:0] outData,
  output logic [WORD_W-1:0] tablePtr,
  output logic              busy,
  output logic              eolIrq
);

  dpCtrl_t dp;
  logic    cntZero, cntOne, eolFlag;

  descRingDmaCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .kick      (kick),
    .memRdValid(memRdValid),
    .outReady  (outReady),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .eolFlag   (eolFlag),
    .dp        (dp),
    .memReq    (memReq),
    .outValid  (outValid),
    .busy      (busy),
    .eolIrq    (eolIrq)
  );

  descRingDmaDatapath #(
    .WORD_W        (WORD_W),
    .MAX_BYTES     (MAX_BYTES),
    .CNT_FIELD_W   (CNT_FIELD_W),
    .RING_MIN_BYTES(RING_MIN_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .dp        (dp),
    .cmdWrData (cmdWrData),
    .memRdData (memRdData),
    .memReqAddr(memReqAddr),
    .outAddr   (outAddr),
    .outData   (outData),
    .tablePtr  (tablePtr),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .eolFlag   (eolFlag)
  );

endmodule

// File: rtl/descRingDmaChecker.sv
module descRingDmaChecker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic [WORD_W-1:0] cmdWrData,
  input logic              memReq,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outAddr,
  input logic [WORD_W-1:0] outData,
  input logic [WORD_W-1:0] tablePtr,
  input logic              busy,
  input logic              eolIrq
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    eolIrq |=> !eolIrq); // R10

  AST_IRQ_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    eolIrq |-> (!busy && $past(busy))); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outAddr))); // R8

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !outValid)); // R3

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    tablePtr[3:0] == 4'b0000); // R4

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdWrEn) |=> (tablePtr == {$past(cmdWrData[WORD_W-1:4]), 4'b0000})); // R2

endmodule

bind descRingDma descRingDmaChecker #(.WORD_W(WORD_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdWrEn  (cmdWrEn),
  .cmdWrData(cmdWrData),
  .memReq   (memReq),
  .outValid (outValid),
  .outReady (outReady),
  .outAddr  (outAddr),
  .outData  (outData),
  .tablePtr (tablePtr),
  .busy     (busy),
  .eolIrq   (eolIrq)
);

// File: tb/descRingDma_test.sv
`timescale 1ns/1ps
module descRingDma_test;

  typedef struct packed {
    logic [31:0] tgt;
    logic [31:0] src;
    logic [31:0] cmd;
    logic [1:0]  stall;
    logic [1:0]  lat;
  } vec_t;

  // target, source, command, stall mode, read latency
  localparam vec_t VECS [0:3] = '{
    '{32'h0000_0100, 32'h4000_0000, 32'h8000_0010, 2'd0, 2'd1},
    '{32'h007F_FE48, 32'h4000_1000, 32'hC000_000A, 2'd1, 2'd3},
    '{32'h0000_0200, 32'h5000_0000, 32'h8000_1000, 2'd0, 2'd1},
    '{32'h0000_0300, 32'h6000_0000, 32'hC000_1FFF, 2'd2, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic        kick = 1'b0;
  logic        memReq;
  logic [31:0] memReqAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outAddr, outData, tablePtr;
  logic        busy, eolIrq;

  always #4 clk = ~clk;

  descRingDma uut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .kick(kick),
    .memReq(memReq), .memReqAddr(memReqAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outData(outData),
    .tablePtr(tablePtr), .busy(busy), .eolIrq(eolIrq)
  );

  bit [31:0]   tbl [bit [31:0]];
  int          memLat = 1;
  int          stallMode = 0;
  int          readCnt;
  logic [31:0] readAddr [0:7];
  logic [31:0] capA [0:2047];
  logic [31:0] capD [0:2047];
  int          capN;
  logic [31:0] ptrFirst;
  int          irqCnt;
  bit          irqWide, irqPrev;
  int          cyc;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  function automatic logic [31:0] dataAt(input logic [31:0] a);
    return a ^ 32'h5A00_00C3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putDesc(input logic [31:0] at, input logic [31:0] tgt,
                         input logic [31:0] src, input logic [31:0] cmd);
    tbl[at]         = tgt;
    tbl[at + 32'd4] = src;
    tbl[at + 32'd8] = cmd;
    tbl[at + 32'd12] = 32'hDEAD_0000;
  endtask

  task automatic clr();
    readCnt = 0;
    capN    = 0;
    irqCnt  = 0;
    irqWide = 1'b0;
  endtask

  task automatic writeCmd(input logic [31:0] v);
    @(negedge clk);
    cmdWrEn   = 1'b1;
    cmdWrData = v;
    @(negedge clk);
    cmdWrEn   = 1'b0;
  endtask

  task automatic pulseKick();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 100000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // Memory model: one read at a time, data after memLat cycles
  initial begin
    forever begin
      @(negedge clk);
      memRdValid = 1'b0;
      if (memReq) begin
        logic [31:0] a;
        a = memReqAddr;
        if (readCnt < 8) readAddr[readCnt] = a;
        readCnt++;
        repeat (memLat) @(negedge clk);
        memRdData  = tbl.exists(a) ? tbl[a] : dataAt(a);
        memRdValid = 1'b1;
      end
    end
  end

  // Output sink with selectable backpressure, plus interrupt monitor
  initial begin
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      case (stallMode)
        1:       outReady = cyc[0];
        2:       outReady = (cyc % 3 == 0);
        default: outReady = 1'b1;
      endcase
      if (outValid && outReady && capN < 2048) begin
        if (capN == 0) ptrFirst = tablePtr;
        capA[capN] = outAddr;
        capD[capN] = outData;
        capN++;
      end
      if (eolIrq) begin
        irqCnt++;
        if (irqPrev) irqWide = 1'b1;
      end
      irqPrev = eolIrq;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 memReq", 32'(memReq), 32'd0);
    chk("R1 outValid", 32'(outValid), 32'd0);
    chk("R1 eolIrq", 32'(eolIrq), 32'd0);
    chk("R1 tablePtr", tablePtr, 32'd0);

    // R2 low nibble cleared on load
    writeCmd(32'h0001_234F);
    @(negedge clk);
    chk("R2 load clears low bits", tablePtr, 32'h0001_2340);

    // Vector table: one descriptor each
    for (int i = 0; i < 4; i++) begin
      logic [31:0] at, expA, expD;
      int bytes, nDw, badA, badD;
      at = 32'h8000 + 32'(16 * i);
      bytes = int'(VECS[i].cmd[12:0]);
      if (bytes > 4096) bytes = 4096;
      nDw = (bytes + 3) / 4;
      clr();
      memLat    = int'(VECS[i].lat);
      stallMode = int'(VECS[i].stall);
      putDesc(at, VECS[i].tgt, VECS[i].src, VECS[i].cmd);
      writeCmd(at);
      pulseKick();
      waitIdle();
      badA = 0;
      badD = 0;
      for (int k = 0; k < capN; k++) begin
        expA = VECS[i].tgt + (VECS[i].cmd[30] ? 32'd0 : 32'(4 * k));
        expD = dataAt(VECS[i].src + 32'(4 * k));
        if (capA[k] !== expA) badA++;
        if (capD[k] !== expD) badD++;
      end
      chk("R5 dword count", 32'(capN), 32'(nDw));
      chk("R6 read count", 32'(readCnt), 32'(3 + nDw));
      chk("R7 target address mismatches", 32'(badA), 32'd0);
      chk("R8 data mismatches under backpressure", 32'(badD), 32'd0);
      chk("R4 pointer while busy", ptrFirst, at + 32'd16);
      chk("R4 pointer after stop", tablePtr, at + 32'd16);
      chk("R10 irq count", 32'(irqCnt), 32'd1);
      chk("R10 irq width", 32'(irqWide), 32'd0);
      chk("R10 busy low", 32'(busy), 32'd0);
      if (i == 0) begin
        chk("R3 read order tgt", readAddr[0], at);
        chk("R3 read order src", readAddr[1], at + 32'd4);
        chk("R3 read order cmd", readAddr[2], at + 32'd8);
        chk("R6 first data read", readAddr[3], VECS[i].src);
      end
    end

    // R9 zero-count chain, R11 continuation
    clr();
    memLat = 1;
    stallMode = 0;
    putDesc(32'hA000, 32'h400, 32'h7000_0000, 32'h0000_0000);
    putDesc(32'hA010, 32'h500, 32'h7000_0100, 32'h8000_0000);
    writeCmd(32'hA000);
    pulseKick();
    waitIdle();
    chk("R9 zero count reads", 32'(readCnt), 32'd6);
    chk("R9 zero count outputs", 32'(capN), 32'd0);
    chk("R11 chain pointer", tablePtr, 32'hA020);
    chk("R10 chain irq count", 32'(irqCnt), 32'd1);

    // R4 wrap in a 16 KB ring (code 0)
    clr();
    putDesc(32'h13FF0, 32'h600, 32'h7100_0000, 32'h0000_0008);
    putDesc(32'h10000, 32'h700, 32'h7200_0000, 32'h8000_0004);
    writeCmd(32'h13FF0);
    pulseKick();
    waitIdle();
    chk("R4 wrap code0 pointer", tablePtr, 32'h10010);
    chk("R11 wrap outputs", 32'(capN), 32'd3);
    chk("R11 wrap second target", capA[2], 32'h700);
    chk("R7 wrap second data", capD[2], dataAt(32'h7200_0000));

    // R4 wrap in a 64 KB ring (code 2)
    clr();
    putDesc(32'h2FFF0, 32'h800, 32'h7300_0000, 32'h0000_0000);
    putDesc(32'h20000, 32'h900, 32'h7400_0000, 32'h8000_0000);
    writeCmd(32'h2FFF2);
    pulseKick();
    waitIdle();
    chk("R4 wrap code2 pointer", tablePtr, 32'h20010);
    chk("R2 size code reads", 32'(readCnt), 32'd6);

    // R11 list extended while running; R2/R3 writes while busy ignored
    clr();
    stallMode = 1;
    putDesc(32'h9000, 32'h1000, 32'h7500_0000, 32'h0000_0040);
    putDesc(32'h9010, 32'h2000, 32'h7600_0000, 32'h8000_0004);
    writeCmd(32'h9000);
    pulseKick();
    for (int n = 0; n < 1000 && capN < 1; n++) @(negedge clk);
    tbl[32'h9018] = 32'h0000_0004;
    putDesc(32'h9020, 32'h3000, 32'h7700_0000, 32'h8000_0008);
    writeCmd(32'h0000_5550);
    pulseKick();
    waitIdle();
    chk("R11 extended outputs", 32'(capN), 32'd19);
    chk("R11 extended last target", capA[17], 32'h3000);
    chk("R2 busy write ignored pointer", tablePtr, 32'h9030);
    chk("R3 busy kick ignored irq", 32'(irqCnt), 32'd1);
    chk("R3 idle after extension", 32'(busy), 32'd0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule